// File: doc/BRIEF.md
# Power-On Strap Capture and Pad Role Controller

This block sits behind a set of shared pads that do two jobs. Right after power-up, five frequency-select pads and one multiplier pad are inputs, and their levels are board straps. A single power-good pin tells the block when the supplies are stable. The first rising edge on that pin, after it has been filtered, stores all six strap levels in one clock cycle. After that the block hands the pads over to their clock role and treats the same pin as an active-low power-down request.

The power-good pin is brought into the block clock domain with a synchroniser. A debounce filter then requires the synchronised level to hold for a set number of cycles before the block acts on a change, so a short glitch does nothing. The capture happens once. Later edges on the pin only drive the power-down request, and only a reset re-arms the capture.

Once the straps are stored, the first three frequency-select pads carry the buffered crystal reference. The remaining frequency-select pads carry the free-running PCI clock, and the multiplier pad carries the programmable 24/48 MHz clock. The pull resistors and the analog pad behaviour sit outside this block, so the pad levels arrive already resolved.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While reset is held and in the cycle after it is released, `strap_o` is 0 and `straps_valid_o`, every output-enable, every pad output and `pwr_down_o` are low.
- R2: On the first filtered rising edge of `pwrgd_pad_i`, all six pad levels are stored together in `strap_o`. Bit i (0..4) holds frequency-select pad i and bit 5 holds the multiplier pad.
- R3: A high pulse on `pwrgd_pad_i` that lasts fewer than DEBOUNCE clock cycles does not store the straps and does not enable the pads.
- R4: All output-enables stay low until the straps are stored. They rise in the same cycle as `straps_valid_o`, on clock edge SYNC_STAGES+DEBOUNCE+1 after `pwrgd_pad_i` goes high.
- R5: Once stored, `strap_o` and `straps_valid_o` do not change until reset, whatever happens later on the pads or on `pwrgd_pad_i`.
- R6: After the straps are stored, `pwr_down_o` rises on clock edge SYNC_STAGES+DEBOUNCE after `pwrgd_pad_i` goes low. It falls again by the same rule when the pin returns high. Before the straps are stored it stays low.
- R7: When the pads are enabled, frequency-select pads 0..2 output `ref_clk_i`, pads 3..4 output `pci_free_clk_i`, and the multiplier pad outputs `prog_clk_i`. A pad whose output-enable is low drives 0.
- R8: While `straps_valid_o` is low, `strap_o` reads 0, whatever the pad levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrgd_pad_i | input | 1 | Power-good, later active-low power-down pin level |
| fs_pad_i | input | 5 | Frequency-select pad levels |
| mult_pad_i | input | 1 | Multiplier pad level |
| ref_clk_i | input | 1 | Buffered crystal reference for pads 0..2 |
| pci_free_clk_i | input | 1 | Free-running PCI clock for pads 3..4 |
| prog_clk_i | input | 1 | Programmable 24/48 MHz clock for the multiplier pad |
| strap_o | output | 6 | Stored strap word {mult, fs[4:0]} |
| straps_valid_o | output | 1 | Straps have been stored |
| fs_oe_o | output | 5 | Output-enable per frequency-select pad |
| mult_oe_o | output | 1 | Output-enable of the multiplier pad |
| fs_pad_o | output | 5 | Frequency-select pad output values |
| mult_pad_o | output | 1 | Multiplier pad output value |
| pwr_down_o | output | 1 | Power-down request |

## Verification
The bench runs through all 64 strap patterns, each from a fresh reset, and compares the stored word with the applied pattern. This would catch swapped or dropped bits. Before each capture it sends a power-good pulse one cycle shorter than the debounce window, which a design without working debounce would latch. It samples the valid flag and the enables one cycle before and at the exact capture edge, which shows a design that drives the pads early or adds a register stage. After capture it changes the pads and toggles the pin. This shows whether a design samples the straps again or mistimes the power-down request. Each pad clock source is driven both high and low on its own so that a wrong pad mapping shows up.

// File: rtl/strap_pkg.sv
// Package: types and constants shared by the strap controller modules.
// Assumes: nothing beyond IEEE 1800-2017.
package strap_pkg;

    // Capture state: waiting for the first filtered rise, or live.
    typedef enum logic {
        ST_SAMPLE = 1'b0,
        ST_LIVE   = 1'b1
    } strap_state_e;

    // Number of frequency-select pads that carry the crystal reference.
    localparam int unsigned REF_PADS = 3;

endpackage

// File: rtl/pg_sync.sv
// Module: pg_sync
// Brings the asynchronous power-good pin level into the clk domain
// through a chain of STAGES flops.
// Assumes: STAGES >= 2; the reset value of the chain is low (not good).
module pg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/pg_filter.sv
// Module: pg_filter
// Debounces the synchronised power-good level. The filtered output takes
// a new value only after the input has disagreed with it on DEBOUNCE
// consecutive clock edges.
// Assumes: DEBOUNCE >= 2; the filtered level resets low.
module pg_filter #(
    parameter int unsigned DEBOUNCE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic filt_o
);

    localparam int unsigned CW = $clog2(DEBOUNCE + 1);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE - 1);

    logic [CW-1:0] cnt_q;
    logic          filt_q;

    // Count the run of disagreeing samples and flip when it is long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else if (level_i != filt_q) begin
            if (cnt_q == LAST) begin
                filt_q <= level_i;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign filt_o = filt_q;

    AST_FILT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(level_i) == filt_q)); // R3

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R3

endmodule

// File: rtl/strap_capture.sv
// Module: strap_capture
// One-shot capture of the strap pads. The first high level of the filtered
// power-good (which resets low, so this is its first rise) stores all pads
// at once and marks the straps valid. After that the filtered level, when
// low, requests power-down.
// Assumes: pad levels are stable around the capture edge (board straps).
module strap_capture
    import strap_pkg::*;
#(
    parameter int unsigned N_FS = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          filt_i,
    input  logic [N_FS-1:0] fs_i,
    input  logic          mult_i,
    output logic [N_FS:0] strap_o,
    output logic          valid_o,
    output logic          pd_o
);

    strap_state_e   state_q;
    logic [N_FS:0]  strap_q;

    // Store the straps once, on the first filtered rise after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SAMPLE;
            strap_q <= '0;
        end else begin
            case (state_q)
                ST_SAMPLE: if (filt_i) begin
                    strap_q <= {mult_i, fs_i};
                    state_q <= ST_LIVE;
                end
                ST_LIVE: state_q <= ST_LIVE;
                default: state_q <= ST_SAMPLE;
            endcase
        end
    end

    assign valid_o = (state_q == ST_LIVE);
    assign strap_o = strap_q;
    assign pd_o    = valid_o & ~filt_i;

    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> (valid_o && $stable(strap_q))); // R5

    AST_ZERO_UNTIL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (strap_q == '0)); // R8

    AST_RISE_NEEDS_FILT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(filt_i)); // R2

endmodule

// File: rtl/pad_role_mux.sv
// Module: pad_role_mux
// Selects the clock each shared pad carries once enabled, and forces the
// output value to 0 while its enable is low.
// Assumes: pads below REF_PADS carry the reference, the rest of the
// frequency-select pads carry the free-running PCI clock.
module pad_role_mux
    import strap_pkg::*;
#(
    parameter int unsigned N_FS = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            ref_clk_i,
    input  logic            pci_clk_i,
    input  logic            prog_clk_i,
    output logic [N_FS-1:0] fs_oe_o,
    output logic            mult_oe_o,
    output logic [N_FS-1:0] fs_pad_o,
    output logic            mult_pad_o
);

    // One lane per frequency-select pad; the source depends on the index.
    for (genvar i = 0; i < N_FS; i++) begin : g_lane
        if (i < REF_PADS) begin : g_ref
            assign fs_pad_o[i] = en_i & ref_clk_i;
        end else begin : g_pci
            assign fs_pad_o[i] = en_i & pci_clk_i;
        end
        assign fs_oe_o[i] = en_i;
    end

    assign mult_oe_o  = en_i;
    assign mult_pad_o = en_i & prog_clk_i;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !mult_oe_o |-> (fs_pad_o == '0 && !mult_pad_o)); // R7

endmodule

// File: rtl/strap_latch_ctrl.sv
// Module: strap_latch_ctrl (top)
// Synchronises and debounces the power-good pin, captures the strap pads
// once, then hands the pads to their clock roles and reports power-down.
// Assumes: pad pull resistors are resolved outside; clocks routed to the
// pads arrive as plain signals.
module strap_latch_ctrl #(
    parameter int unsigned N_FS        = 5,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEBOUNCE    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pwrgd_pad_i,
    input  logic [N_FS-1:0] fs_pad_i,
    input  logic            mult_pad_i,
    input  logic            ref_clk_i,
    input  logic            pci_free_clk_i,
    input  logic            prog_clk_i,
    output logic [N_FS:0]   strap_o,
    output logic            straps_valid_o,
    output logic [N_FS-1:0] fs_oe_o,
    output logic            mult_oe_o,
    output logic [N_FS-1:0] fs_pad_o,
    output logic            mult_pad_o,
    output logic            pwr_down_o
);

    logic pg_sync_w;
    logic pg_filt_w;
    logic valid_w;

    pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pwrgd_pad_i),
        .sync_o  (pg_sync_w)
    );

    pg_filter #(.DEBOUNCE(DEBOUNCE)) u_filter (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pg_sync_w),
        .filt_o  (pg_filt_w)
    );

    strap_capture #(.N_FS(N_FS)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .filt_i  (pg_filt_w),
        .fs_i    (fs_pad_i),
        .mult_i  (mult_pad_i),
        .strap_o (strap_o),
        .valid_o (valid_w),
        .pd_o    (pwr_down_o)
    );

    pad_role_mux #(.N_FS(N_FS)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (valid_w),
        .ref_clk_i  (ref_clk_i),
        .pci_clk_i  (pci_free_clk_i),
        .prog_clk_i (prog_clk_i),
        .fs_oe_o    (fs_oe_o),
        .mult_oe_o  (mult_oe_o),
        .fs_pad_o   (fs_pad_o),
        .mult_pad_o (mult_pad_o)
    );

    assign straps_valid_o = valid_w;

    AST_OE_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_oe_o == {N_FS{straps_valid_o}}) && (mult_oe_o == straps_valid_o)); // R4

    AST_PD_ONLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_o |-> straps_valid_o); // R6

    AST_PD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (straps_valid_o && $fell(pg_filt_w)) |-> pwr_down_o); // R6

endmodule

// File: tb/strap_latch_ctrl_bench.sv
module strap_latch_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_FS = 5;
    localparam int SYNC = 2;
    localparam int DEB  = 4;
    localparam int LAT  = SYNC + DEB + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwrgd = 1'b0;
    logic [N_FS-1:0] fs_pad = '0;
    logic            mult_pad = 1'b0;
    logic            ref_clk = 1'b0, pci_clk = 1'b0, prog_clk = 1'b0;
    logic [N_FS:0]   strap;
    logic            valid, mult_oe, mult_out, pd;
    logic [N_FS-1:0] fs_oe, fs_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strap_latch_ctrl #(.N_FS(N_FS), .SYNC_STAGES(SYNC), .DEBOUNCE(DEB)) u_strap_latch_ctrl (
        .clk(clk), .rst_n(rst_n), .pwrgd_pad_i(pwrgd), .fs_pad_i(fs_pad),
        .mult_pad_i(mult_pad), .ref_clk_i(ref_clk), .pci_free_clk_i(pci_clk),
        .prog_clk_i(prog_clk), .strap_o(strap), .straps_valid_o(valid),
        .fs_oe_o(fs_oe), .mult_oe_o(mult_oe), .fs_pad_o(fs_out),
        .mult_pad_o(mult_out), .pwr_down_o(pd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Expected pad output word for given source levels (R7 mapping).
    function automatic int exp_fs(input bit r, input bit p);
        int v = 0;
        for (int i = 0; i < N_FS; i++) v |= ((i < 3) ? r : p) << i;
        return v;
    endfunction

    task automatic check_pads(input bit r, input bit p, input bit g);
        ref_clk = r; pci_clk = p; prog_clk = g;
        #1;
        chk(fs_out == exp_fs(r, p), "R7 fs pads", fs_out, exp_fs(r, p));
        chk(mult_out == g, "R7 mult pad", mult_out, g);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < 64; p++) begin
            // Fresh reset with the strap pattern applied to the pads.
            @(negedge clk);
            rst_n = 1'b0; pwrgd = 1'b0;
            fs_pad = p[N_FS-1:0]; mult_pad = p[N_FS];
            ref_clk = 1'b1; pci_clk = 1'b1; prog_clk = 1'b1;
            edges(3);
            rst_n = 1'b1;
            edges(1);
            // R1 reset state
            chk(strap == 0 && !valid && fs_oe == 0 && !mult_oe, "R1 reset outputs", {valid, strap}, 0);
            chk(fs_out == 0 && !mult_out && !pd, "R1 reset pads/pd", {pd, mult_out, fs_out}, 0);

            // R3 glitch one cycle short of the debounce window
            pwrgd = 1'b1;
            edges(DEB - 1);
            pwrgd = 1'b0;
            edges(12);
            chk(!valid && fs_oe == 0, "R3 short pulse ignored", {fs_oe, valid}, 0);
            chk(strap == 0, "R8 strap reads zero before valid", strap, 0);

            // R4 exact capture edge
            pwrgd = 1'b1;
            edges(LAT - 1);
            chk(!valid && fs_oe == 0 && !mult_oe, "R4 enables low before capture", {mult_oe, fs_oe, valid}, 0);
            chk(strap == 0, "R8 strap zero one edge before capture", strap, 0);
            edges(1);
            chk(valid && fs_oe == '1 && mult_oe, "R4 enables rise with valid", {mult_oe, fs_oe, valid}, 'h7f);
            chk(strap == p[N_FS:0], "R2 strap captured", strap, p);

            // R7 pad mapping, each source alone
            check_pads(1'b1, 1'b0, 1'b0);
            check_pads(1'b0, 1'b1, 1'b0);
            check_pads(1'b0, 1'b0, 1'b1);

            // R6 power-down timing; pads changed meanwhile (R5)
            fs_pad = ~p[N_FS-1:0]; mult_pad = ~p[N_FS];
            @(negedge clk);
            pwrgd = 1'b0;
            edges(SYNC + DEB - 1);
            chk(!pd, "R6 pd not yet", pd, 0);
            edges(1);
            chk(pd, "R6 pd asserted", pd, 1);
            pwrgd = 1'b1;
            edges(SYNC + DEB);
            chk(!pd, "R6 pd released", pd, 0);
            edges(4);
            chk(valid && strap == p[N_FS:0], "R5 no resample on later rise", strap, p);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule